// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block turns an already selected input clock enable into the timing pulses a UART needs. It produces an oversample pulse, used by the receiver to sample its line, and a 1x baud pulse, used by the transmitter to shift out bits. There are two ways to make them. In integer mode, a reloading down-counter divides the input enable, and a prescaler then divides the result by 4 or by 16. In fractional mode, a phase accumulator adds a programmed increment and uses its carry to make the pulse. This gives a much finer choice of baud rates.

Software loads the configuration through a single write strobe. The block ignores that strobe while the UART reports that its transmitter or receiver is busy. It also shows this lock on an active flag. A sleep input freezes all counting unless the sleep-run option has been latched. A change of mode clears every counter, so the new mode always starts from a known phase.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick_o` and `os_tick_o` are 0. The latched configuration is integer mode with divisor 0, increment 0, prescale 16 and sleep-run off, and all counters are 0.
- R2: In integer mode, the down-counter moves only on edges that advance. When the counter is 0 on such an edge, it reloads from the divisor and `os_tick_o` is 1 for the next cycle. Otherwise the counter decrements. The result is one oversample pulse every divisor+1 advancing edges.
- R3: In integer mode, `tick_o` pulses together with every 4th oversample pulse when the high-speed bit (`cfg_high_speed_i`=1) is latched, and with every 16th when it is clear. Whenever `tick_o` is 1, `os_tick_o` is also 1.
- R4: In fractional mode (`cfg_frac_mode_i`=1), a 20-bit accumulator adds the increment on every advancing edge. The carry out of bit 19 drives `tick_o` and `os_tick_o` together for the next cycle.
- R5: An edge advances a counter only when `clk_en_i` is 1. An edge with `clk_en_i`=0 produces no pulse in the following cycle.
- R6: While `sleep_i` is 1 and the latched sleep-run bit is 0, no counter moves and no pulse appears. With sleep-run latched as 1, counting continues through sleep.
- R7: `active_o` is 1 in any cycle where `tx_busy_i` or `rx_busy_i` is 1, and 0 otherwise.
- R8: A configuration write (`cfg_we_i`=1) is accepted only when `active_o` is 0, and takes effect from the next edge. A write made while `active_o` is 1 leaves every latched field unchanged.
- R9: An accepted write that changes the mode bit clears the down-counter, the prescaler and the accumulator on that edge. Both outputs are then 0 in the following cycle, whatever `clk_en_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Enable from the selected baud clock source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_frac_mode_i | input | 1 | 0 integer mode, 1 fractional mode |
| cfg_high_speed_i | input | 1 | Integer prescale: 1 gives /4, 0 gives /16 |
| cfg_sleep_run_i | input | 1 | 1 keeps counting during sleep |
| cfg_div_i | input | DIV_W | Integer divisor value |
| cfg_inc_i | input | ACC_W | Fractional increment value |
| sleep_i | input | 1 | Sleep request |
| tx_busy_i | input | 1 | Transmitter busy |
| rx_busy_i | input | 1 | Receiver busy |
| tick_o | output | 1 | 1x baud pulse |
| os_tick_o | output | 1 | Oversample pulse |
| active_o | output | 1 | Clock request active, configuration locked |

## Verification
Both pulse outputs are registered. A pulse caused by an advancing edge is therefore visible from just after that edge until the next one. A configuration write becomes visible in the counting one edge after its strobe. `active_o` is combinational and follows the busy inputs in the same cycle. The bench drives every input 2 ns after a falling edge. A behavioural model updates on each rising edge using the same inputs the design sees. The outputs are compared on the falling edge, where they have settled. The pulse-count windows start only after a settling interval, and each window covers a whole number of periods, so the expected count does not depend on the counter's phase.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } baud_mode_e;

  localparam int unsigned PRESCALE_FAST = 4;
  localparam int unsigned PRESCALE_SLOW = 16;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             lock_i,
  input  logic             mode_i,
  input  logic             hs_i,
  input  logic             srun_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [ACC_W-1:0] inc_i,
  output baud_mode_e       mode_o,
  output logic             hs_o,
  output logic             srun_o,
  output logic [DIV_W-1:0] div_o,
  output logic [ACC_W-1:0] inc_o,
  output logic             mode_chg_o
);
  logic accept;
  baud_mode_e mode_d;

  assign accept     = we_i & ~lock_i;
  assign mode_d     = baud_mode_e'(mode_i);
  assign mode_chg_o = accept & (mode_d != mode_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_INT;
      hs_o   <= 1'b0;
      srun_o <= 1'b0;
      div_o  <= '0;
      inc_o  <= '0;
    end else if (accept) begin
      mode_o <= mode_d;
      hs_o   <= hs_i;
      srun_o <= srun_i;
      div_o  <= div_i;
      inc_o  <= inc_i;
    end
  end
endmodule

// File: rtl/baud_int_div.sv
module baud_int_div
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             hs_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             os_o,
  output logic             tick_o
);
  localparam int unsigned PRE_W = $clog2(PRESCALE_SLOW);
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(PRESCALE_FAST - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(PRESCALE_SLOW - 1);

  logic [DIV_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_lim;

  assign pre_lim = hs_i ? LIM_FAST : LIM_SLOW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      os_o   <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      os_o   <= 1'b0;
      tick_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
        pre_q <= '0;
      end else if (step_i) begin
        if (cnt_q == '0) begin
          os_o  <= 1'b1;
          cnt_q <= div_i;
          // >= so a prescale switch from /16 to /4 cannot overrun
          if (pre_q >= pre_lim) begin
            tick_o <= 1'b1;
            pre_q  <= '0;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= step_i & sum[ACC_W];
      if (step_i) acc_q <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             cfg_we_i,
  input  logic             cfg_frac_mode_i,
  input  logic             cfg_high_speed_i,
  input  logic             cfg_sleep_run_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [ACC_W-1:0] cfg_inc_i,
  input  logic             sleep_i,
  input  logic             tx_busy_i,
  input  logic             rx_busy_i,
  output logic             tick_o,
  output logic             os_tick_o,
  output logic             active_o
);
  baud_mode_e       mode_q;
  logic             hs_q, srun_q, mode_chg;
  logic [DIV_W-1:0] div_q;
  logic [ACC_W-1:0] inc_q;
  logic             run, step_int, step_frac;
  logic             int_os, int_tick, frac_tick;

  assign active_o = tx_busy_i | rx_busy_i;

  baud_cfg_regs #(.DIV_W(DIV_W), .ACC_W(ACC_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .lock_i    (active_o),
    .mode_i    (cfg_frac_mode_i),
    .hs_i      (cfg_high_speed_i),
    .srun_i    (cfg_sleep_run_i),
    .div_i     (cfg_div_i),
    .inc_i     (cfg_inc_i),
    .mode_o    (mode_q),
    .hs_o      (hs_q),
    .srun_o    (srun_q),
    .div_o     (div_q),
    .inc_o     (inc_q),
    .mode_chg_o(mode_chg)
  );

  assign run       = clk_en_i & (~sleep_i | srun_q);
  assign step_int  = run & (mode_q == MODE_INT);
  assign step_frac = run & (mode_q == MODE_FRAC);

  baud_int_div #(.DIV_W(DIV_W)) u_int (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_int),
    .clr_i (mode_chg),
    .hs_i  (hs_q),
    .div_i (div_q),
    .os_o  (int_os),
    .tick_o(int_tick)
  );

  baud_frac_acc #(.ACC_W(ACC_W)) u_frac (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step_frac),
    .clr_i (mode_chg),
    .inc_i (inc_q),
    .tick_o(frac_tick)
  );

  assign tick_o    = (mode_q == MODE_FRAC) ? frac_tick : int_tick;
  assign os_tick_o = (mode_q == MODE_FRAC) ? frac_tick : int_os;
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned ACC_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_i,
  input logic             sleep_i,
  input logic             cfg_we_i,
  input logic             active_o,
  input logic             tick_o,
  input logic             os_tick_o,
  input baud_mode_e       mode_q,
  input logic             hs_q,
  input logic             srun_q,
  input logic [DIV_W-1:0] div_q,
  input logic [ACC_W-1:0] inc_q,
  input logic             mode_chg
);
  // R5
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> !os_tick_o && !tick_o);

  // R6
  sleep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !srun_q) |=> !os_tick_o && !tick_o);

  // R3
  tick_in_os_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> os_tick_o);

  // R4
  frac_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FRAC && os_tick_o) |-> tick_o);

  // R8
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && active_o) |=> $stable(div_q) && $stable(inc_q) &&
      $stable(mode_q) && $stable(hs_q) && $stable(srun_q));

  // R9
  mode_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !tick_o && !os_tick_o);
endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W), .ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_en_i (clk_en_i),
  .sleep_i  (sleep_i),
  .cfg_we_i (cfg_we_i),
  .active_o (active_o),
  .tick_o   (tick_o),
  .os_tick_o(os_tick_o),
  .mode_q   (mode_q),
  .hs_q     (hs_q),
  .srun_q   (srun_q),
  .div_q    (div_q),
  .inc_q    (inc_q),
  .mode_chg (mode_chg)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  localparam int DIV_W = 16;
  localparam int ACC_W = 20;
  localparam longint ACC_MOD = 64'd1 << ACC_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, we = 1'b0, mode = 1'b0, hs = 1'b0, srun = 1'b0;
  logic sleep = 1'b0, txb = 1'b0, rxb = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [ACC_W-1:0] inc = '0;
  logic tick, os, act;

  always #5 clk = ~clk;

  baud_tick_gen #(.DIV_W(DIV_W), .ACC_W(ACC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .cfg_we_i(we),
    .cfg_frac_mode_i(mode), .cfg_high_speed_i(hs), .cfg_sleep_run_i(srun),
    .cfg_div_i(div), .cfg_inc_i(inc), .sleep_i(sleep),
    .tx_busy_i(txb), .rx_busy_i(rxb),
    .tick_o(tick), .os_tick_o(os), .active_o(act)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input longint a, input longint e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, a, e);
    end
  endtask

  // behavioural reference
  bit m_frac, m_hs, m_srun, e_os, e_tick;
  longint m_div, m_inc, m_cnt, m_pre, m_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_frac = 0; m_hs = 0; m_srun = 0; m_div = 0; m_inc = 0;
      m_cnt = 0; m_pre = 0; m_acc = 0; e_os = 0; e_tick = 0;
    end else begin
      bit ok_wr;
      ok_wr = we && !(txb || rxb);
      e_os = 0; e_tick = 0;
      if (ok_wr && (mode != m_frac)) begin
        m_cnt = 0; m_pre = 0; m_acc = 0;
      end else if (en && (!sleep || m_srun)) begin
        if (m_frac) begin
          m_acc = m_acc + m_inc;
          if (m_acc >= ACC_MOD) begin
            m_acc = m_acc - ACC_MOD; e_os = 1; e_tick = 1;
          end
        end else if (m_cnt == 0) begin
          e_os = 1; m_cnt = m_div;
          if (m_pre >= (m_hs ? 3 : 15)) begin e_tick = 1; m_pre = 0; end
          else m_pre = m_pre + 1;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
      if (ok_wr) begin
        m_frac = mode; m_hs = hs; m_srun = srun; m_div = div; m_inc = inc;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(os === e_os, m_frac ? "R4 os_tick" : "R2 os_tick", os, e_os);
      check(tick === e_tick, m_frac ? "R4 tick" : "R3 tick", tick, e_tick);
      check(act === (txb | rxb), "R7 active", act, txb | rxb);
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic wr(input bit md, input bit h, input bit s, input int d, input int i);
    mode = md; hs = h; srun = s; div = DIV_W'(d); inc = ACC_W'(i); we = 1'b1;
    cyc(1);
    we = 1'b0;
  endtask

  task automatic win(input int n, input bit tog, output int n_os, output int n_tk);
    n_os = 0; n_tk = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_os += int'(os); n_tk += int'(tick);
      #2;
      if (tog) en = ~en;
    end
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b;
    cyc(3);
    check(tick === 1'b0 && os === 1'b0, "R1 reset outputs", tick | os, 0);
    rst_n = 1'b1;
    cyc(2);
    en = 1'b1;
    // R1: default divisor 0, /16
    win(32, 0, a, b);
    check(a == 32, "R1 default os count", a, 32);
    check(b == 2, "R1 default tick count", b, 2);

    // R2 / R3 divisor 2, /4
    wr(0, 1, 0, 2, 0);
    cyc(20);
    win(48, 0, a, b);
    check(a == 16, "R2 os per div+1", a, 16);
    check(b == 4, "R3 tick every 4", b, 4);

    // R3 /16
    wr(0, 0, 0, 0, 0);
    cyc(40);
    win(64, 0, a, b);
    check(a == 64, "R2 div0 os", a, 64);
    check(b == 4, "R3 tick every 16", b, 4);

    // R5 enable gating
    wr(0, 1, 0, 0, 0);
    cyc(20);
    win(64, 1, a, b);
    check(a == 32, "R5 half enables os", a, 32);
    check(b == 8, "R5 half enables tick", b, 8);
    en = 1'b1;

    // R6 sleep
    sleep = 1'b1;
    cyc(1);
    win(40, 0, a, b);
    check(a == 0 && b == 0, "R6 sleep stops", a + b, 0);
    wr(0, 1, 1, 0, 0);
    win(64, 0, a, b);
    check(a == 64, "R6 sleep run", a, 64);
    sleep = 1'b0;

    // R9 / R4 switch to fractional
    wr(1, 0, 0, 0, 1 << 18);
    @(negedge clk);
    check(os === 1'b0 && tick === 1'b0, "R9 cleared on mode change", os | tick, 0);
    #2;
    cyc(8);
    win(64, 0, a, b);
    check(b == 16, "R4 quarter increment ticks", b, 16);
    check(a == 16, "R4 os with tick", a, 16);

    // R8 lock while busy
    txb = 1'b1;
    wr(0, 1, 0, 5, 0);
    cyc(2);
    check(act === 1'b1, "R7 busy tx", act, 1);
    win(64, 0, a, b);
    check(b == 16, "R8 write ignored while active", b, 16);
    txb = 1'b0; rxb = 1'b1;
    wr(0, 1, 0, 5, 0);
    win(64, 0, a, b);
    check(b == 16, "R8 rx busy lock", b, 16);
    rxb = 1'b0;
    cyc(1);
    check(act === 1'b0, "R7 idle", act, 0);
    wr(0, 1, 0, 2, 0);
    cyc(20);
    win(48, 0, a, b);
    check(a == 16, "R8 accepted write", a, 16);

    // fine fractional step, model compares every cycle
    wr(1, 0, 0, 0, 'h33333);
    cyc(300);
    wr(0, 0, 0, 3, 0);
    cyc(200);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule